// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends characters on the single bidirectional data wire of a half-duplex smart card link. Each character goes out as a low start bit, the data bits least significant first, and an even parity bit. Each bit lasts one elementary time unit (ETU), which is a parameter-set number of baud ticks. After the parity bit the block releases the wire and looks at it once, in the middle of the following ETU. A low level there means the card is reporting a bad character. The wire is open drain: the block only ever pulls it low, and a released wire reads high.

When the card reports an error, the block copies the byte again from its holding register and sends it again straight away. During a resend the end-of-frame and holding-register-empty flags stay low, so a DMA engine fed from the transmit request is not started again. A transfer of N bytes therefore stays correct across errors. A sticky error flag records that a card error was seen, and only software clears it. A parameter can bound the number of resends; once the bound is used up, the character is counted as finished and the error flag stays set.

Top module: `scard_tx`

## Requirements
- R1: After reset, `dre_flag` and `tend_flag` are 1, `err_flag` is 0 and `line_drive_low` is 0, so the wire is released.
- R2: A frame is 13 ETUs of ETU_TICKS baud ticks each. ETU 0 is the start bit (low). ETUs 1 to 8 carry data bits 0 to 7. ETU 9 carries even parity over the data. ETUs 10 to 12 are released. `line_drive_low` is 1 only while a 0 bit is being sent.
- R3: The wire is sampled on the baud tick where the tick count inside ETU 10 equals ETU_TICKS/2. A low level there sets `err_flag` on that clock edge.
- R4: `tx_req` equals `dre_flag` AND `tx_irq_en`. `err_req` equals `err_flag` AND `err_irq_en`.
- R5: `err_flag` is sticky. It clears only on a clock with `err_clr` high and no error sample at the same edge; an error sample wins.
- R6: A frame that received an error signal does not set `tend_flag` or `dre_flag`. The same byte is sent again, starting in the ETU right after ETU 12.
- R7: A frame with no error signal sets `tend_flag` and `dre_flag` together on the clock edge that ends ETU 12.
- R8: A write (`wr_en`) while `dre_flag` is 1 stores `wr_data`, clears `dre_flag` and `tend_flag` on that edge, and starts a frame at the next clock. A write while `dre_flag` is 0 is ignored, and the byte on the wire is unchanged.
- R9: With MAX_RETRY > 0, at most MAX_RETRY resends follow one write. If the last allowed resend also receives an error signal, `tend_flag` and `dre_flag` are set and `err_flag` stays 1. MAX_RETRY = 0 means resend without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle baud strobe; ETU_TICKS strobes make one ETU |
| wr_en | input | 1 | Holding register write strobe (software or DMA) |
| wr_data | input | DW | Byte to send |
| err_clr | input | 1 | Software clear of the error flag |
| tx_irq_en | input | 1 | Enable for the transmit interrupt/DMA request |
| err_irq_en | input | 1 | Enable for the error interrupt request |
| line_in | input | 1 | Sensed level of the shared data wire |
| line_drive_low | output | 1 | 1 pulls the wire low; 0 releases it |
| dre_flag | output | 1 | Holding register empty |
| tend_flag | output | 1 | Character finished (no resend pending) |
| err_flag | output | 1 | Card error signal seen (sticky) |
| tx_req | output | 1 | Transmit interrupt/DMA request |
| err_req | output | 1 | Error interrupt request |

## Verification
A wrong ETU count or bit index shows on `line_drive_low` within one ETU, because the bench compares the wire drive with its own model on every clock. A lost frame-error state shows when the frame ends, 13 ETUs after the start. Either `tend_flag` rises too early, or the byte is not sent again in the next ETU. A wrong resend count appears only when the last allowed resend finishes, as a flag that rises one frame early or late. A holding register that takes a write while full shows only in the byte decoded from the next resend.

// File: rtl/scard_tx_pkg.sv
package scard_tx_pkg;
   // line levels on the shared open-drain wire
   localparam logic START_LEVEL = 1'b0;
   localparam logic IDLE_LEVEL  = 1'b1;
   // frame layout after the parity ETU
   localparam int SAMPLE_GAP_ETUS = 1;   // error sample sits in ETU parity+1
   localparam int GUARD_ETUS      = 2;   // released ETUs after the sample ETU

   function automatic logic even_par(input logic [63:0] v, input int n);
      logic p;
      p = 1'b0;
      for (int i = 0; i < n; i++) p = p ^ v[i];
      return p;
   endfunction
endpackage

// File: rtl/scard_etu_timer.sv
module scard_etu_timer
   import scard_tx_pkg::*;
#(
   parameter int ETU_TICKS = 16,
   parameter int DW        = 8,
   localparam int PAR_ETU  = DW + 1,
   localparam int SMP_ETU  = PAR_ETU + SAMPLE_GAP_ETUS,
   localparam int LAST_ETU = SMP_ETU + GUARD_ETUS,
   localparam int EW       = $clog2(LAST_ETU + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   output logic [EW-1:0] etu,
   output logic          sample_stb,
   output logic          frame_end
);
   localparam int CW = (ETU_TICKS > 1) ? $clog2(ETU_TICKS) : 1;
   localparam logic [CW-1:0] LAST_T   = CW'(ETU_TICKS - 1);
   localparam logic [CW-1:0] SAMPLE_T = CW'(ETU_TICKS / 2);
   localparam logic [EW-1:0] LAST_E   = EW'(LAST_ETU);
   localparam logic [EW-1:0] SMP_E    = EW'(SMP_ETU);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         etu <= '0;
      end else if (!run) begin
         cnt <= '0;
         etu <= '0;
      end else if (tick) begin
         if (cnt == LAST_T) begin
            cnt <= '0;
            etu <= (etu == LAST_E) ? '0 : etu + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign sample_stb = run && tick && (etu == SMP_E)  && (cnt == SAMPLE_T);
   assign frame_end  = run && tick && (etu == LAST_E) && (cnt == LAST_T);

   p_etu_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      etu <= LAST_E);
   p_idle_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (etu == '0));
endmodule

// File: rtl/scard_char_shift.sv
module scard_char_shift
   import scard_tx_pkg::*;
#(
   parameter int DW       = 8,
   parameter int EW       = 4,
   localparam int PAR_ETU = DW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic [EW-1:0] etu,
   output logic          bit_val
);
   logic [DW-1:0] sh;
   logic          par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         par <= 1'b0;
      end else if (load) begin
         sh  <= din;
         par <= even_par(64'(din), DW);
      end
   end

   always_comb begin
      bit_val = IDLE_LEVEL;
      if (etu == '0) bit_val = START_LEVEL;
      for (int i = 0; i < DW; i++)
         if (etu == EW'(i + 1)) bit_val = sh[i];
      if (etu == EW'(PAR_ETU)) bit_val = par;
   end
endmodule

// File: rtl/scard_retry_gate.sv
module scard_retry_gate #(
   parameter int MAX_RETRY = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bump,
   output logic ok
);
   if (MAX_RETRY == 0) begin : g_unlimited
      logic unused_gate;
      assign unused_gate = clk ^ rst_n ^ clr ^ bump;
      assign ok = 1'b1;
   end else begin : g_counted
      localparam int RW = $clog2(MAX_RETRY + 1);
      localparam logic [RW-1:0] LIM = RW'(MAX_RETRY);
      logic [RW-1:0] used;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     used <= '0;
         else if (clr)   used <= '0;
         else if (bump)  used <= used + 1'b1;
      end
      assign ok = (used < LIM);

      p_retry_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
         used <= LIM);
      p_no_bump_at_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (used == LIM) && !clr |=> (used == LIM));
   end
endmodule

// File: rtl/scard_tx.sv
module scard_tx
   import scard_tx_pkg::*;
#(
   parameter int DW        = 8,
   parameter int ETU_TICKS = 16,
   parameter int MAX_RETRY = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          err_clr,
   input  logic          tx_irq_en,
   input  logic          err_irq_en,
   input  logic          line_in,
   output logic          line_drive_low,
   output logic          dre_flag,
   output logic          tend_flag,
   output logic          err_flag,
   output logic          tx_req,
   output logic          err_req
);
   localparam int LAST_ETU = DW + 1 + SAMPLE_GAP_ETUS + GUARD_ETUS;
   localparam int EW       = $clog2(LAST_ETU + 1);

   initial begin
      assert (DW >= 1 && DW <= 64) else $error("scard_tx: DW out of range");
      assert (ETU_TICKS >= 2) else $error("scard_tx: ETU_TICKS below 2");
      assert (MAX_RETRY >= 0) else $error("scard_tx: MAX_RETRY negative");
   end

   logic          busy, ferr, bit_val, retry_ok;
   logic          sample_stb, frame_end;
   logic [EW-1:0] etu;
   logic [DW-1:0] hold;

   wire accept   = wr_en && dre_flag;
   wire card_nak = sample_stb && !line_in;
   wire retry    = frame_end && ferr && retry_ok;
   wire finish   = frame_end && !retry;

   scard_etu_timer #(.ETU_TICKS(ETU_TICKS), .DW(DW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(baud_tick),
      .etu(etu), .sample_stb(sample_stb), .frame_end(frame_end));

   scard_char_shift #(.DW(DW), .EW(EW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept || retry),
      .din(accept ? wr_data : hold), .etu(etu), .bit_val(bit_val));

   scard_retry_gate #(.MAX_RETRY(MAX_RETRY)) u_retry (
      .clk(clk), .rst_n(rst_n), .clr(accept), .bump(retry), .ok(retry_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         hold      <= '0;
         dre_flag  <= 1'b1;
         tend_flag <= 1'b1;
      end else if (accept) begin
         busy      <= 1'b1;
         hold      <= wr_data;
         dre_flag  <= 1'b0;
         tend_flag <= 1'b0;
      end else if (finish) begin
         busy      <= 1'b0;
         dre_flag  <= 1'b1;
         tend_flag <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ferr <= 1'b0;
      else if (accept || retry)  ferr <= 1'b0;
      else if (card_nak)         ferr <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_flag <= 1'b0;
      else if (card_nak) err_flag <= 1'b1;
      else if (err_clr)  err_flag <= 1'b0;
   end

   assign line_drive_low = busy && (bit_val == START_LEVEL);
   assign tx_req         = dre_flag && tx_irq_en;
   assign err_req        = err_flag && err_irq_en;

   p_release_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_drive_low);
   p_flags_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend_flag) |-> $rose(dre_flag));
   p_no_end_on_resend_r6: assert property (@(posedge clk) disable iff (!rst_n)
      retry |=> (!tend_flag && busy));
   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !err_clr |=> err_flag);
   p_full_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !dre_flag |=> $stable(hold));
   p_nak_sets_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      card_nak |=> err_flag);
endmodule

// File: tb/tb_scard_tx.sv
`timescale 1ns/1ps
module tb_scard_tx;
   localparam int DW = 8, ETU = 4, MAXR = 2, LASTE = 12;

   logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
   logic wr_en = 1'b0, err_clr = 1'b0, tie = 1'b0, rie = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic drive_low, dre, tend, err, txr, errr, card_pull, line;

   always #10 clk = ~clk;   // 50 MHz

   assign line = ~(drive_low | card_pull);

   scard_tx #(.DW(DW), .ETU_TICKS(ETU), .MAX_RETRY(MAXR)) dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_data(wr_data), .err_clr(err_clr), .tx_irq_en(tie), .err_irq_en(rie),
      .line_in(line), .line_drive_low(drive_low), .dre_flag(dre),
      .tend_flag(tend), .err_flag(err), .tx_req(txr), .err_req(errr));

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference state
   bit m_busy, m_empty, m_tend, m_err, m_ferr;
   int m_etu, m_tk, m_retries, nack_cnt = 0, frames_done = 0;
   logic [DW-1:0] m_byte, m_hold;
   logic cap [0:LASTE];
   int sent_q[$];

   assign card_pull = m_busy && (nack_cnt > 0) && (m_etu >= 10) && (m_etu <= 11);

   function automatic logic exp_drive();
      if (!m_busy || m_etu > 9) return 1'b0;
      if (m_etu == 0) return 1'b1;
      if (m_etu == 9) return ~(^m_byte);
      return ~m_byte[m_etu-1];
   endfunction

   always @(negedge clk) baud_tick <= ~baud_tick;

   always @(posedge clk) begin
      bit fe, eset;
      int b;
      fe = 0; eset = 0;
      if (!rst_n) begin
         m_busy = 0; m_empty = 1; m_tend = 1; m_err = 0; m_ferr = 0;
         m_etu = 0; m_tk = 0; m_retries = 0; m_byte = '0; m_hold = '0;
      end else begin
         if (m_busy && baud_tick) begin
            if (m_etu == 10 && m_tk == ETU/2 && line == 1'b0) begin
               m_ferr = 1; eset = 1;
            end
            if (m_tk == ETU-1) begin
               m_tk = 0;
               if (m_etu == LASTE) fe = 1; else m_etu++;
            end else m_tk++;
         end
         if (fe) begin
            b = 0;
            for (int i = 0; i < DW; i++) b |= int'(cap[i+1]) << i;
            sent_q.push_back(b);
            chk("R2", "start bit level", int'(cap[0]), 0);
            chk("R2", "even parity bit", int'(cap[9]), int'(^b[7:0]));
            frames_done++;
            if (nack_cnt > 0) nack_cnt--;
            m_etu = 0;
            if (m_ferr && (MAXR == 0 || m_retries < MAXR)) begin
               m_retries++; m_ferr = 0; m_byte = m_hold;
            end else begin
               m_busy = 0; m_empty = 1; m_tend = 1;
            end
         end
         if (eset) m_err = 1; else if (err_clr) m_err = 0;
         if (wr_en && m_empty) begin
            m_hold = wr_data; m_byte = wr_data; m_empty = 0; m_tend = 0;
            m_busy = 1; m_etu = 0; m_tk = 0; m_ferr = 0; m_retries = 0;
         end
      end
   end

   // per-clock comparison and wire capture, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R2", "line_drive_low", int'(drive_low), int'(exp_drive()));
         chk("R7", "dre_flag", int'(dre), int'(m_empty));
         chk("R7", "tend_flag", int'(tend), int'(m_tend));
         chk("R3", "err_flag", int'(err), int'(m_err));
         chk("R4", "tx_req", int'(txr), int'(m_empty && tie));
         chk("R4", "err_req", int'(errr), int'(m_err && rie));
         if (m_busy) cap[m_etu] = line;
      end
   end

   task automatic do_write(input logic [DW-1:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_frames(input int target);
      while (frames_done < target) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset dre", int'(dre), 1);
      chk("R1", "reset tend", int'(tend), 1);
      chk("R1", "reset err", int'(err), 0);
      chk("R1", "reset wire released", int'(drive_low), 0);
      tie = 1'b1; rie = 1'b1;
      @(negedge clk);
      chk("R4", "tx_req with enable", int'(txr), 1);

      do_write(8'hA5);
      chk("R8", "write clears dre", int'(dre), 0);
      chk("R8", "write clears tend", int'(tend), 0);
      wait_frames(1);
      chk("R7", "clean frame tend", int'(tend), 1);
      chk("R7", "clean frame dre", int'(dre), 1);
      chk("R2", "decoded byte A5", sent_q[$], 8'hA5);

      nack_cnt = 1;
      do_write(8'h3C);
      wait_frames(2);
      chk("R6", "tend held during resend", int'(tend), 0);
      chk("R6", "no tx_req during resend", int'(txr), 0);
      chk("R3", "error seen", int'(err), 1);
      chk("R4", "err_req raised", int'(errr), 1);
      do_write(8'hFF);
      wait_frames(3);
      chk("R8", "ignored write, resent byte", sent_q[$], 8'h3C);
      chk("R6", "first attempt byte", sent_q[sent_q.size()-2], 8'h3C);
      chk("R7", "resend done tend", int'(tend), 1);
      chk("R5", "err stays set", int'(err), 1);

      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      chk("R5", "err cleared by software", int'(err), 0);
      chk("R4", "err_req dropped", int'(errr), 0);

      nack_cnt = 5;
      do_write(8'h81);
      wait_frames(6);
      chk("R9", "limit reached tend", int'(tend), 1);
      chk("R9", "limit reached dre", int'(dre), 1);
      chk("R9", "limit reached err kept", int'(err), 1);
      chk("R9", "three attempts of 81", int'(sent_q[3] == 8'h81 && sent_q[4] == 8'h81
                                              && sent_q[5] == 8'h81), 1);
      chk("R9", "no fourth attempt", sent_q.size(), 6);
      nack_cnt = 0;

      repeat (20) @(negedge clk);
      chk("R2", "wire idle after limit", int'(drive_low), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule